// File: doc/BRIEF.md
# Conversion Mode and Ready Controller

This block sits between a converter core and a serial register interface. It decides when a conversion runs and when a new result reaches the data register. It also keeps the ready, error and channel flags that software sees in the status byte. A 2-bit mode field chooses free-running conversion, a single conversion that ends in sleep, or no conversion. A periodic enable, `conv_tick`, stands for the converter's internal clock. Every timing window below is counted in those ticks.

After reset, after a mode write, or after a channel change while converting, the block pulses `filter_rst`. It then waits two full conversion periods before it delivers the first result. Later results in free-running mode arrive once per period. A fixed number of ticks before each update, ready drops, so that a reader does not fetch a word that is about to be replaced.

Each raw result is coded as offset binary or as straight binary. Results that are out of range are clamped, and the error flag is raised at the same time as ready. `load_pulse` marks each update, so that the serial side can reload its output shifter. A result that nobody reads is overwritten.

Top module: `conv_ready_ctrl`

## Requirements
- R1: `mode_sel` is decoded as 00 = continuous, 10 = single, 11 = power-down and 01 = reserved. A mode write with 11 or 01 stops all conversions and clears `data_ready`. Further ticks then change neither `data_out` nor `data_ready`.
- R2: After reset or a restart, the first update takes place on the tick that completes 2*PERIOD_TICKS ticks. Cycles in which `conv_tick` is low are not counted.
- R3: In continuous mode, every update after the first comes PERIOD_TICKS ticks after the previous one. Each update pulses `load_pulse` for one cycle. A result that is not read is replaced by the next one.
- R4: Within each period after the first result, `data_ready` goes low on tick PERIOD_TICKS-PRE_TICKS. It stays low until the update on tick PERIOD_TICKS.
- R5: A `rd_done` pulse clears `data_ready` and leaves `data_out` unchanged.
- R6: In single mode, exactly one result is produced, after 2*PERIOD_TICKS ticks. Afterwards the block stops, and `data_ready` and `data_out` hold until a read or a new mode write.
- R7: A mode write, or a change of `chan_sel` while converting, does three things: `filter_rst` is high in the next cycle, `data_ready` is cleared, and the two-period settling of R2 starts again. Status bits 1:0 show the new channel.
- R8: Bipolar coding (`uni_en`=0) gives `raw_val` (two's complement) with its MSB inverted. Unipolar coding (`uni_en`=1) gives `raw_val` shifted left by one bit.
- R9: Out-of-range results are clamped as follows: `raw_ovr` gives all ones, `raw_udr` gives all zeros, and a negative `raw_val` in unipolar mode gives all zeros. In each case `err_flag` is set together with ready. A mode write that starts a conversion clears `err_flag`.
- R10: `status_byte` is {not ready, error, 0, 0, 1, 1 if DATA_W>16 else 0, channel[1:0]}. Its value after reset is 0x88 for an 8-bit or 16-bit result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| mode_wr | input | 1 | one-cycle mode register write strobe |
| mode_sel | input | 2 | mode field written with `mode_wr` |
| uni_en | input | 1 | 1 = unipolar coding, 0 = bipolar |
| chan_sel | input | 2 | selected input channel |
| conv_tick | input | 1 | converter clock enable |
| raw_val | input | DATA_W | raw result, two's complement |
| raw_ovr | input | 1 | raw result above range |
| raw_udr | input | 1 | raw result below range |
| rd_done | input | 1 | data register read finished |
| data_out | output | DATA_W | data register |
| data_ready | output | 1 | result available |
| err_flag | output | 1 | last result was clamped |
| status_byte | output | 8 | packed status |
| filter_rst | output | 1 | filter and modulator reset pulse |
| load_pulse | output | 1 | data register updated this cycle |

## Verification
A wrong tick count shows up as a ready edge one or more ticks away from the period boundary. It can be seen within a single period, both on the first result after a restart and inside the pre-update window. A wrong mode state, such as a single conversion that keeps running or a power-down that still converts, shows up at the next period boundary as an extra `load_pulse` or as changed data. A coding or clamp fault is visible on `data_out` and `err_flag` as soon as the next update lands, because the sweeps pass every raw code through both codings.

// File: rtl/cmr_pkg.sv
package cmr_pkg;

    typedef enum logic [1:0] {
        MD_CONT   = 2'b00,
        MD_RSVD   = 2'b01,
        MD_SINGLE = 2'b10,
        MD_OFF    = 2'b11
    } cmr_mode_e;

    localparam logic [1:0] STAT_FIXED = 2'b00;

    function automatic logic mode_runs(input logic [1:0] m);
        return (m == MD_CONT) || (m == MD_SINGLE);
    endfunction

    function automatic logic [7:0] pack_status(input logic rdy, input logic err,
                                               input logic wide, input logic [1:0] ch);
        return {~rdy, err, STAT_FIXED, 1'b1, wide, ch};
    endfunction

endpackage

// File: rtl/cmr_timer.sv
module cmr_timer #(
    parameter int PERIOD_TICKS = 16,
    parameter int PRE_TICKS    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    input  logic tick,
    output logic pre_hit,
    output logic end_hit
);
    localparam int CW = $clog2(2 * PERIOD_TICKS + 1);
    localparam logic [CW-1:0] LAST_FIRST = CW'(2 * PERIOD_TICKS - 1);
    localparam logic [CW-1:0] LAST_NEXT  = CW'(PERIOD_TICKS - 1);
    localparam logic [CW-1:0] PRE_OFF    = CW'(PRE_TICKS);

    logic [CW-1:0] cnt;
    logic          first;
    logic [CW-1:0] last;

    assign last    = first ? LAST_FIRST : LAST_NEXT;
    assign end_hit = run && tick && (cnt == last);
    assign pre_hit = run && tick && (cnt == last - PRE_OFF);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt   <= '0;
            first <= 1'b1;
        end else if (run && tick) begin
            if (cnt == last) begin
                cnt   <= '0;
                first <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cmr_coder.sv
module cmr_coder #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] raw,
    input  logic              ovr,
    input  logic              udr,
    input  logic              uni,
    output logic [DATA_W-1:0] code,
    output logic              clamp
);
    localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};

    always_comb begin
        clamp = 1'b0;
        code  = raw ^ MSB_MASK;
        if (ovr) begin
            code  = '1;
            clamp = 1'b1;
        end else if (udr) begin
            code  = '0;
            clamp = 1'b1;
        end else if (uni) begin
            if (raw[DATA_W-1]) begin
                code  = '0;
                clamp = 1'b1;
            end else begin
                code = {raw[DATA_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/conv_ready_ctrl.sv
module conv_ready_ctrl
    import cmr_pkg::*;
#(
    parameter int DATA_W       = 16,
    parameter int PERIOD_TICKS = 16,
    parameter int PRE_TICKS    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  logic [1:0]        mode_sel,
    input  logic              uni_en,
    input  logic [1:0]        chan_sel,
    input  logic              conv_tick,
    input  logic [DATA_W-1:0] raw_val,
    input  logic              raw_ovr,
    input  logic              raw_udr,
    input  logic              rd_done,
    output logic [DATA_W-1:0] data_out,
    output logic              data_ready,
    output logic              err_flag,
    output logic [7:0]        status_byte,
    output logic              filter_rst,
    output logic              load_pulse
);
    localparam logic WIDE = (DATA_W > 16);

    logic              running;
    logic              single;
    logic [1:0]        conv_ch;
    logic              rdy_q;
    logic              err_q;
    logic [DATA_W-1:0] data_q;
    logic              filt_q;
    logic              load_q;

    logic              ch_move;
    logic              restart;
    logic              pre_hit;
    logic              end_hit;
    logic [DATA_W-1:0] code;
    logic              clamp;

    assign ch_move = running && (chan_sel != conv_ch);
    assign restart = mode_wr || ch_move;

    cmr_timer #(
        .PERIOD_TICKS(PERIOD_TICKS),
        .PRE_TICKS   (PRE_TICKS)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .restart(restart),
        .run    (running),
        .tick   (conv_tick),
        .pre_hit(pre_hit),
        .end_hit(end_hit)
    );

    cmr_coder #(.DATA_W(DATA_W)) u_coder (
        .raw  (raw_val),
        .ovr  (raw_ovr),
        .udr  (raw_udr),
        .uni  (uni_en),
        .code (code),
        .clamp(clamp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b1;
            single  <= 1'b0;
            conv_ch <= 2'b00;
            rdy_q   <= 1'b0;
            err_q   <= 1'b0;
            data_q  <= '0;
            filt_q  <= 1'b0;
            load_q  <= 1'b0;
        end else begin
            filt_q  <= restart;
            load_q  <= 1'b0;
            conv_ch <= chan_sel;
            if (mode_wr) begin
                rdy_q   <= 1'b0;
                running <= mode_runs(mode_sel);
                single  <= (mode_sel == MD_SINGLE);
                if (mode_runs(mode_sel)) err_q <= 1'b0;
            end else if (ch_move) begin
                rdy_q <= 1'b0;
            end else if (end_hit) begin
                data_q <= code;
                err_q  <= clamp;
                rdy_q  <= 1'b1;
                load_q <= 1'b1;
                if (single) running <= 1'b0;
            end else if (pre_hit || rd_done) begin
                rdy_q <= 1'b0;
            end
        end
    end

    assign data_out    = data_q;
    assign data_ready  = rdy_q;
    assign err_flag    = err_q;
    assign filter_rst  = filt_q;
    assign load_pulse  = load_q;
    assign status_byte = pack_status(rdy_q, err_q, WIDE, conv_ch);
endmodule

// File: rtl/conv_ready_ctrl_chk.sv
module conv_ready_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       mode_wr,
    input logic [1:0] mode_sel,
    input logic       conv_tick,
    input logic       rd_done,
    input logic       data_ready,
    input logic       err_flag,
    input logic       filter_rst,
    input logic       load_pulse
);
    p_off_clears_rdy_r1: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && mode_sel[0]) |=> !data_ready);

    p_rdy_rise_loads_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(data_ready) |-> load_pulse);

    p_read_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_done && !conv_tick && !mode_wr) |=> !data_ready);

    p_write_resets_filter_r7: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> filter_rst);

    p_no_load_on_restart_r7: assert property (@(posedge clk) disable iff (rst)
        filter_rst |-> !load_pulse);

    p_err_with_load_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> load_pulse);
endmodule

bind conv_ready_ctrl conv_ready_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_wr   (mode_wr),
    .mode_sel  (mode_sel),
    .conv_tick (conv_tick),
    .rd_done   (rd_done),
    .data_ready(data_ready),
    .err_flag  (err_flag),
    .filter_rst(filter_rst),
    .load_pulse(load_pulse)
);

// File: tb/conv_ready_ctrl_bench.sv
module conv_ready_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W   = 8;
    localparam int P   = 6;
    localparam int PRE = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mode_wr = 1'b0;
    logic [1:0]   mode_sel = 2'b00;
    logic         uni_en = 1'b0;
    logic [1:0]   chan_sel = 2'b00;
    logic         conv_tick = 1'b0;
    logic [W-1:0] raw_val = '0;
    logic         raw_ovr = 1'b0;
    logic         raw_udr = 1'b0;
    logic         rd_done = 1'b0;
    logic [W-1:0] data_out;
    logic         data_ready;
    logic         err_flag;
    logic [7:0]   status_byte;
    logic         filter_rst;
    logic         load_pulse;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] held;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_ready_ctrl #(.DATA_W(W), .PERIOD_TICKS(P), .PRE_TICKS(PRE)) u_conv_ready_ctrl (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_sel(mode_sel), .uni_en(uni_en),
        .chan_sel(chan_sel), .conv_tick(conv_tick), .raw_val(raw_val), .raw_ovr(raw_ovr),
        .raw_udr(raw_udr), .rd_done(rd_done), .data_out(data_out), .data_ready(data_ready),
        .err_flag(err_flag), .status_byte(status_byte), .filter_rst(filter_rst),
        .load_pulse(load_pulse)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) conv_tick = 1'b1;
            @(negedge clk) conv_tick = 1'b0;
        end
    endtask

    task automatic write_mode(input logic [1:0] m);
        @(negedge clk) begin mode_wr = 1'b1; mode_sel = m; end
        @(negedge clk) mode_wr = 1'b0;
        check("R7 filter reset after mode write", filter_rst, 1);
        check("R7 ready cleared by mode write", data_ready, 0);
    endtask

    task automatic read_pulse();
        @(negedge clk) rd_done = 1'b1;
        @(negedge clk) rd_done = 1'b0;
    endtask

    function automatic logic [W:0] model(input logic [W-1:0] r, input logic uni,
                                         input logic ov, input logic ud);
        if (ov) return {1'b1, {W{1'b1}}};
        if (ud) return {1'b1, {W{1'b0}}};
        if (uni) return r[W-1] ? {1'b1, {W{1'b0}}} : {1'b0, r[W-2:0], 1'b0};
        return {1'b0, r + 8'h80};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R10 reset status", status_byte, 8'h88);
        check("R2 reset ready", data_ready, 0);
        check("R9 reset error", err_flag, 0);

        // first result after reset
        raw_val = 8'h25;
        ticks(2*P - 1);
        check("R2 no result before two periods", data_ready, 0);
        ticks(1);
        check("R2 ready at two periods", data_ready, 1);
        check("R8 bipolar code", data_out, 8'hA5);
        check("R3 load pulse", load_pulse, 1);
        check("R10 status ready bit", status_byte, 8'h08);

        // pre-update window
        raw_val = 8'h10;
        ticks(P - PRE - 1);
        check("R4 ready before window", data_ready, 1);
        ticks(1);
        check("R4 ready dropped in window", data_ready, 0);
        check("R10 status not ready", status_byte[7], 1);
        ticks(PRE - 1);
        check("R4 ready still low", data_ready, 0);
        ticks(1);
        check("R4 ready after update", data_ready, 1);
        check("R3 next result", data_out, 8'h90);

        // unread results replaced
        raw_val = 8'h01; ticks(P);
        raw_val = 8'h7F; ticks(P);
        check("R3 latest result kept", data_out, 8'hFF);
        check("R3 load on replace", load_pulse, 1);

        read_pulse();
        check("R5 read clears ready", data_ready, 0);
        check("R5 data held after read", data_out, 8'hFF);

        // coding sweeps
        for (int u = 0; u < 2; u++) begin
            uni_en = u[0];
            for (int v = 0; v < 256; v++) begin
                logic [W:0] e;
                raw_val = v[W-1:0];
                e = model(v[W-1:0], u[0], 1'b0, 1'b0);
                ticks(P);
                check(u ? "R8 unipolar sweep" : "R8 bipolar sweep", data_out, e[W-1:0]);
                check("R9 sweep error flag", err_flag, e[W]);
            end
        end

        // clamps
        uni_en = 1'b0; raw_val = 8'h12; raw_ovr = 1'b1;
        ticks(P);
        check("R9 over-range clamp", data_out, 8'hFF);
        check("R9 error with ready", {err_flag, data_ready}, 2'b11);
        raw_ovr = 1'b0; raw_udr = 1'b1;
        ticks(P);
        check("R9 under-range clamp", data_out, 8'h00);
        check("R9 error set", err_flag, 1);
        raw_udr = 1'b0;
        write_mode(2'b00);
        check("R9 error cleared by start", err_flag, 0);
        raw_val = 8'h33;
        ticks(2*P - 1);
        check("R2 restart settling", data_ready, 0);
        ticks(1);
        check("R2 restart result", data_ready, 1);
        check("R8 restart code", data_out, 8'hB3);

        // channel change
        @(negedge clk) chan_sel = 2'b10;
        @(negedge clk);
        check("R7 filter reset on channel", filter_rst, 1);
        check("R7 ready cleared on channel", data_ready, 0);
        check("R10 status channel", status_byte[1:0], 2'b10);
        ticks(2*P - 1);
        check("R7 settling after channel", data_ready, 0);
        ticks(1);
        check("R7 result after channel", data_ready, 1);

        // single conversion
        raw_val = 8'h40;
        write_mode(2'b10);
        ticks(2*P);
        check("R6 single result", data_out, 8'hC0);
        check("R6 single ready", data_ready, 1);
        raw_val = 8'h01;
        ticks(3*P);
        check("R6 ready held after single", data_ready, 1);
        check("R6 data held after single", data_out, 8'hC0);
        read_pulse();
        check("R5 read in single", data_ready, 0);
        ticks(2*P);
        check("R6 no second conversion", {data_ready, data_out}, {1'b0, 8'hC0});

        // power-down and reserved
        write_mode(2'b00);
        ticks(2*P);
        check("R1 continuous running", data_ready, 1);
        held = data_out;
        raw_val = 8'h55;
        write_mode(2'b11);
        check("R1 power-down clears ready", data_ready, 0);
        ticks(3*P);
        check("R1 no conversion in power-down", {data_ready, data_out}, {1'b0, held});
        write_mode(2'b01);
        ticks(3*P);
        check("R1 reserved converts nothing", {data_ready, data_out}, {1'b0, held});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule